// File: doc/BRIEF.md
# Script Instruction Fetch Sequencer

This block sits at the front of a small DMA script processor. A host write to the script pointer starts it. It then reads the script one 32-bit word at a time from memory and keeps only one read outstanding. It works out from the opcode byte how many words the current instruction spans. Once the instruction is complete, it presents the decoded fields to an execution unit through a valid/ready handshake.

After the execution unit reports completion, the sequencer fetches the next instruction from the advanced pointer. It keeps running until one of three things happens: a memory response carries an error, the execution unit reports an error, or an interrupt-type instruction is decoded. When it halts it raises a sticky interrupt flag, and for error halts a sticky error flag as well. A fresh host write to the pointer clears both flags and starts a new run.

Top module: `scr_fetch_seq`

## Requirements
- R1: After reset the block issues no read and presents no instruction, and both `seq_irq` and `seq_err` are low.
- R2: A host write accepted while idle or halted loads the pointer and clears `seq_irq` and `seq_err`. On the next cycle the block requests a read at exactly the written address.
- R3: At most one read is outstanding at a time. A request holds its address until `mem_rd_ready`. Each good response advances the pointer by 4, and the next request uses the advanced pointer.
- R4: The first word's bits 31:30 give the class (00 block move, 01 I/O, 10 transfer-control, 11 memory move). A direct instruction spans 2 words. A memory move spans 3, and its third word appears on `ins_shadow`. For every other class, `ins_shadow` is zero.
- R5: Bit 29 of the first word marks an indirect form. An indirect form adds two words when bit 28 is set and one word when it is clear. The added words appear on `ins_ext0` and then `ins_ext1`, and unused slots read zero.
- R6: `ins_opcode` is bits 31:24 of the first word, `ins_count` is bits 23:0, and `ins_addr` is the second word. `ins_valid` and all fields stay stable until `ins_ready`. A read request and `ins_valid` are never high together.
- R7: After `exe_done`, the next instruction's first read is at the address that follows the last word fetched.
- R8: A transfer-control instruction with bit 27 set is an interrupt instruction. It is fully fetched, never handed off, and it halts the block with `seq_irq` set and `seq_err` clear.
- R9: A memory response with `mem_rsp_err` set halts the block with `seq_err` and `seq_irq` set. It produces no `ins_valid`.
- R10: `exe_err` during execution halts the block with `seq_err` and `seq_irq` set.
- R11: A host write arriving while the block is fetching, presenting or executing is ignored.
- R12: `seq_irq` and `seq_err` stay set until the next accepted host write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Host write strobe for the script pointer |
| host_wr_data | input | AW | Start address written by the host |
| mem_rd_valid | output | 1 | Read request valid |
| mem_rd_ready | input | 1 | Read request accepted |
| mem_rd_addr | output | AW | Read address |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | DW | Read response word |
| mem_rsp_err | input | 1 | Read response error |
| ins_valid | output | 1 | Decoded instruction valid |
| ins_ready | input | 1 | Execution unit takes instruction |
| ins_opcode | output | 8 | Opcode byte |
| ins_count | output | DW-8 | Byte count field |
| ins_addr | output | DW | Second word |
| ins_shadow | output | DW | Third word of a memory move |
| ins_ext0 | output | DW | First indirect extra word |
| ins_ext1 | output | DW | Second indirect extra word |
| exe_done | input | 1 | Execution finished |
| exe_err | input | 1 | Execution failed |
| seq_irq | output | 1 | Sticky halt interrupt |
| seq_err | output | 1 | Sticky error flag |

## Verification
The hardest situation to reach is a memory error in the middle of a multi-word instruction, while earlier words have already been stored and the pointer has moved. The bench plants an error marker at the second word of a memory-move instruction and restarts the script there. Busy-time host writes are hard to hit by chance, so the bench issues one while the second instruction is executing. Memory stalls and variable latencies, with instruction lengths from 2 to 5 words, make each fetch count meet back-pressure at different phases.

// File: rtl/scr_pkg.sv
package scr_pkg;

  localparam int unsigned SCR_SLOTS = 5;
  localparam int unsigned SCR_IDX_W = $clog2(SCR_SLOTS + 1);

  localparam logic [1:0] CLS_XFER    = 2'b10;
  localparam logic [1:0] CLS_MEMMOVE = 2'b11;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_REQ, SQ_RSP, SQ_ISSUE, SQ_EXEC, SQ_HALT
  } sq_state_e;

  // words an instruction spans, from its opcode byte
  function automatic logic [SCR_IDX_W-1:0] fetch_count(input logic [7:0] op);
    logic [SCR_IDX_W-1:0] n;
    n = SCR_IDX_W'(2);
    if (op[7:6] == CLS_MEMMOVE) n = n + SCR_IDX_W'(1);
    if (op[5]) n = n + (op[4] ? SCR_IDX_W'(2) : SCR_IDX_W'(1));
    return n;
  endfunction

  function automatic logic is_memmove(input logic [7:0] op);
    return op[7:6] == CLS_MEMMOVE;
  endfunction

  // interrupt-type instruction halts the sequencer
  function automatic logic halts_here(input logic [7:0] op);
    return (op[7:6] == CLS_XFER) && op[3];
  endfunction

endpackage

// File: rtl/scr_ptr_reg.sv
module scr_ptr_reg #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  output logic [AW-1:0] ptr
);

  localparam logic [AW-1:0] WORD_BYTES = AW'(4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr <= '0;
    else if (load) ptr <= load_val;
    else if (step) ptr <= ptr + WORD_BYTES;
  end

endmodule

// File: rtl/scr_word_bank.sv
module scr_word_bank #(
  parameter int unsigned DW    = 32,
  parameter int unsigned SLOTS = 5,
  parameter int unsigned IDX_W = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      wr,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic [DW-1:0]             wr_data,
  output logic [SLOTS-1:0][DW-1:0]  slots
);

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [DW-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             word_q <= '0;
      else if (clr)                           word_q <= '0;
      else if (wr && wr_idx == IDX_W'(s))     word_q <= wr_data;
    end
    assign slots[s] = word_q;
  end

endmodule

// File: rtl/scr_fetch_seq.sv
module scr_fetch_seq
  import scr_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr_en,
  input  logic [AW-1:0] host_wr_data,
  output logic          mem_rd_valid,
  input  logic          mem_rd_ready,
  output logic [AW-1:0] mem_rd_addr,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  input  logic          mem_rsp_err,
  output logic          ins_valid,
  input  logic          ins_ready,
  output logic [7:0]    ins_opcode,
  output logic [DW-9:0] ins_count,
  output logic [DW-1:0] ins_addr,
  output logic [DW-1:0] ins_shadow,
  output logic [DW-1:0] ins_ext0,
  output logic [DW-1:0] ins_ext1,
  input  logic          exe_done,
  input  logic          exe_err,
  output logic          seq_irq,
  output logic          seq_err
);

  localparam int unsigned SLOTS = SCR_SLOTS;
  localparam int unsigned IDX_W = SCR_IDX_W;

  sq_state_e                 state_q;
  logic [IDX_W-1:0]          idx_q;
  logic [AW-1:0]             ptr_q;
  logic [SLOTS-1:0][DW-1:0]  slots;
  logic [7:0]                op0;

  // named internal events
  logic start_evt, rsp_evt, rsp_good, rsp_bad, ins_complete;
  logic issue_evt, done_evt, fail_evt, bank_clr;

  assign op0          = slots[0][DW-1 -: 8];
  assign start_evt    = host_wr_en && (state_q == SQ_IDLE || state_q == SQ_HALT);
  assign rsp_evt      = (state_q == SQ_RSP) && mem_rsp_valid;
  assign rsp_good     = rsp_evt && !mem_rsp_err;
  assign rsp_bad      = rsp_evt && mem_rsp_err;
  assign ins_complete = rsp_good && (idx_q != '0) &&
                        ((idx_q + 1'b1) == fetch_count(op0));
  assign issue_evt    = ins_valid && ins_ready;
  assign done_evt     = (state_q == SQ_EXEC) && exe_done && !exe_err;
  assign fail_evt     = (state_q == SQ_EXEC) && exe_err;
  assign bank_clr     = start_evt || done_evt;

  scr_ptr_reg #(.AW(AW)) i_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_evt),
    .load_val (host_wr_data),
    .step     (rsp_good),
    .ptr      (ptr_q)
  );

  scr_word_bank #(.DW(DW), .SLOTS(SLOTS), .IDX_W(IDX_W)) i_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (bank_clr),
    .wr      (rsp_good),
    .wr_idx  (idx_q),
    .wr_data (mem_rsp_data),
    .slots   (slots)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      idx_q   <= '0;
      seq_irq <= 1'b0;
      seq_err <= 1'b0;
    end else begin
      case (state_q)
        SQ_IDLE, SQ_HALT: begin
          if (start_evt) begin
            state_q <= SQ_REQ;
            idx_q   <= '0;
            seq_irq <= 1'b0;
            seq_err <= 1'b0;
          end
        end
        SQ_REQ: begin
          if (mem_rd_ready) state_q <= SQ_RSP;
        end
        SQ_RSP: begin
          if (rsp_bad) begin
            state_q <= SQ_HALT;
            seq_irq <= 1'b1;
            seq_err <= 1'b1;
          end else if (rsp_good) begin
            idx_q <= idx_q + 1'b1;
            if (!ins_complete) begin
              state_q <= SQ_REQ;
            end else if (halts_here(op0)) begin
              state_q <= SQ_HALT;
              seq_irq <= 1'b1;
            end else begin
              state_q <= SQ_ISSUE;
            end
          end
        end
        SQ_ISSUE: begin
          if (issue_evt) state_q <= SQ_EXEC;
        end
        SQ_EXEC: begin
          if (fail_evt) begin
            state_q <= SQ_HALT;
            seq_irq <= 1'b1;
            seq_err <= 1'b1;
          end else if (done_evt) begin
            state_q <= SQ_REQ;
            idx_q   <= '0;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign mem_rd_valid = (state_q == SQ_REQ);
  assign mem_rd_addr  = ptr_q;
  assign ins_valid    = (state_q == SQ_ISSUE);

  assign ins_opcode = op0;
  assign ins_count  = slots[0][DW-9:0];
  assign ins_addr   = slots[1];
  assign ins_shadow = is_memmove(op0) ? slots[2] : '0;
  assign ins_ext0   = is_memmove(op0) ? slots[3] : slots[2];
  assign ins_ext1   = is_memmove(op0) ? slots[4] : slots[3];

endmodule

// File: rtl/scr_fetch_seq_chk.sv
module scr_fetch_seq_chk #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] host_wr_data,
  input logic          start_evt,
  input logic          rsp_evt,
  input logic          mem_rsp_err,
  input logic          mem_rd_valid,
  input logic          mem_rd_ready,
  input logic [AW-1:0] mem_rd_addr,
  input logic [AW-1:0] ptr_q,
  input logic          ins_valid,
  input logic          ins_ready,
  input logic [7:0]    ins_opcode,
  input logic [DW-9:0] ins_count,
  input logic [DW-1:0] ins_addr,
  input logic          seq_irq,
  input logic          seq_err
);

  AST_START_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> mem_rd_valid && mem_rd_addr == $past(host_wr_data) && !seq_irq); // R2

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr)); // R3

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_evt && !mem_rsp_err |=> ptr_q == $past(ptr_q) + AW'(4)); // R3

  AST_INS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid && !ins_ready |=> ins_valid && $stable(ins_opcode) && $stable(ins_count) && $stable(ins_addr)); // R6

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_valid && ins_valid)); // R6

  AST_MEMERR_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_evt && mem_rsp_err |=> !ins_valid && !mem_rd_valid && seq_err); // R9

  AST_ERR_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |-> seq_irq); // R10

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    seq_irq && !start_evt |=> seq_irq); // R12

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    seq_irq |-> !mem_rd_valid && !ins_valid); // R8

endmodule

bind scr_fetch_seq scr_fetch_seq_chk #(.AW(AW), .DW(DW)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .host_wr_data (host_wr_data),
  .start_evt    (start_evt),
  .rsp_evt      (rsp_evt),
  .mem_rsp_err  (mem_rsp_err),
  .mem_rd_valid (mem_rd_valid),
  .mem_rd_ready (mem_rd_ready),
  .mem_rd_addr  (mem_rd_addr),
  .ptr_q        (ptr_q),
  .ins_valid    (ins_valid),
  .ins_ready    (ins_ready),
  .ins_opcode   (ins_opcode),
  .ins_count    (ins_count),
  .ins_addr     (ins_addr),
  .seq_irq      (seq_irq),
  .seq_err      (seq_err)
);

// File: tb/test_scr_fetch_seq.sv
`timescale 1ns/1ps
module test_scr_fetch_seq;

  logic        clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic        d_rst = 1'b0;
  logic        d_wr = 1'b0, d_rdy = 1'b0, d_rspv = 1'b0, d_rspe = 1'b0;
  logic        d_insr = 1'b0, d_done = 1'b0, d_exerr = 1'b0;
  logic [31:0] d_wrdata = '0, d_rspd = '0;

  logic        mem_rd_valid, ins_valid, seq_irq, seq_err;
  logic [31:0] mem_rd_addr, ins_addr, ins_shadow, ins_ext0, ins_ext1;
  logic [7:0]  ins_opcode;
  logic [23:0] ins_count;

  scr_fetch_seq i_scr_fetch_seq (
    .clk(clk), .rst_n(d_rst),
    .host_wr_en(d_wr), .host_wr_data(d_wrdata),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(d_rdy), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(d_rspv), .mem_rsp_data(d_rspd), .mem_rsp_err(d_rspe),
    .ins_valid(ins_valid), .ins_ready(d_insr),
    .ins_opcode(ins_opcode), .ins_count(ins_count), .ins_addr(ins_addr),
    .ins_shadow(ins_shadow), .ins_ext0(ins_ext0), .ins_ext1(ins_ext1),
    .exe_done(d_done), .exe_err(d_exerr),
    .seq_irq(seq_irq), .seq_err(seq_err)
  );

  int n_checks = 0, n_fail = 0, cyc = 0;
  logic [31:0] mem [64];

  // reference model: 0 idle 1 req 2 rsp 3 issue 4 exec 5 halt
  int          m_ph = 0;
  logic [31:0] m_ptr = '0;
  logic [31:0] mq [$];
  logic        m_irq = 1'b0, m_err = 1'b0;

  // stimulus bookkeeping
  logic        pend_wr = 1'b0;
  logic [31:0] pend_data = '0, rsp_addr = '0;
  int rsp_cnt = 0, ex_cnt = 0, issued = 0, exerr_at = -1, err_idx = 63;

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int words_of(input logic [31:0] w);
    int n = 2;
    if (w[31:30] == 2'b11) n += 1;
    if (w[29]) n += (w[28] ? 2 : 1);
    return n;
  endfunction

  function automatic logic [31:0] slot_or_zero(input int k);
    return (k < mq.size()) ? mq[k] : 32'h0;
  endfunction

  task automatic model_step();
    if (!d_rst) begin
      m_ph = 0; m_ptr = '0; m_irq = 0; m_err = 0; mq.delete();
    end else begin
      case (m_ph)
        0, 5: if (d_wr) begin
          m_ptr = d_wrdata; mq.delete(); m_irq = 0; m_err = 0; m_ph = 1;
        end
        1: if (d_rdy) m_ph = 2;
        2: if (d_rspv) begin
          if (d_rspe) begin
            m_err = 1; m_irq = 1; m_ph = 5;
          end else begin
            mq.push_back(d_rspd);
            m_ptr += 4;
            if (mq.size() >= 2 && mq.size() == words_of(mq[0])) begin
              if (mq[0][31:30] == 2'b10 && mq[0][27]) begin m_irq = 1; m_ph = 5; end
              else m_ph = 3;
            end else m_ph = 1;
          end
        end
        3: if (d_insr) m_ph = 4;
        4: if (d_exerr) begin m_err = 1; m_irq = 1; m_ph = 5; end
           else if (d_done) begin mq.delete(); m_ph = 1; end
        default: m_ph = 0;
      endcase
    end
  endtask

  task automatic compare();
    int b;
    check(mem_rd_valid == (m_ph == 1), "R3 mem_rd_valid", 32'(mem_rd_valid), 32'(m_ph == 1));
    if (m_ph == 1) check(mem_rd_addr == m_ptr, "R7 mem_rd_addr", mem_rd_addr, m_ptr);
    check(ins_valid == (m_ph == 3), "R6 ins_valid", 32'(ins_valid), 32'(m_ph == 3));
    if (m_ph == 3 && ins_valid) begin
      b = (mq[0][31:30] == 2'b11) ? 3 : 2;
      check(ins_opcode == mq[0][31:24], "R6 opcode", 32'(ins_opcode), 32'(mq[0][31:24]));
      check(ins_count == mq[0][23:0], "R6 count", 32'(ins_count), 32'(mq[0][23:0]));
      check(ins_addr == mq[1], "R6 addr", ins_addr, mq[1]);
      check(ins_shadow == ((b == 3) ? mq[2] : 32'h0), "R4 shadow", ins_shadow, (b == 3) ? mq[2] : 32'h0);
      check(ins_ext0 == slot_or_zero(b), "R5 ext0", ins_ext0, slot_or_zero(b));
      check(ins_ext1 == slot_or_zero(b + 1), "R5 ext1", ins_ext1, slot_or_zero(b + 1));
    end
    check(seq_irq == m_irq, "R12 seq_irq", 32'(seq_irq), 32'(m_irq));
    check(seq_err == m_err, "R12 seq_err", 32'(seq_err), 32'(m_err));
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  // cycle loop: model step, compare, then drive the next inputs
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      model_step();
      compare();
      d_rst = (cyc >= 3);
      d_wr = 1'b0;
      if (pend_wr && d_rst) begin d_wr = 1'b1; d_wrdata = pend_data; pend_wr = 1'b0; end
      d_rspv = 1'b0; d_rspe = 1'b0;
      if (rsp_cnt > 0) begin
        rsp_cnt--;
        if (rsp_cnt == 0) begin
          d_rspv = 1'b1;
          d_rspd = mem[rsp_addr[7:2]];
          d_rspe = (int'(rsp_addr[7:2]) == err_idx);
        end
      end
      d_rdy = (cyc % 3) != 1;
      if (mem_rd_valid && d_rdy) begin rsp_addr = mem_rd_addr; rsp_cnt = 1 + cyc % 2; end
      d_done = 1'b0; d_exerr = 1'b0;
      if (ex_cnt > 0) begin
        ex_cnt--;
        if (ex_cnt == 0) begin
          if (issued == exerr_at) d_exerr = 1'b1; else d_done = 1'b1;
        end
      end
      d_insr = (cyc % 4) != 0;
      if (ins_valid && d_insr) begin issued++; ex_cnt = 1 + cyc % 3; end
      if (cyc > 100000) begin
        check(1'b0, "watchdog", 32'(cyc), 32'd100000);
        finish_run();
      end
    end
  end

  initial begin
    int base;
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    mem[16] = 32'h0000_0010; mem[17] = 32'h0000_1000;                          // direct block move
    mem[18] = 32'h4A00_0003; mem[19] = 32'h1234_5678;                          // direct I/O
    mem[20] = 32'hC000_0020; mem[21] = 32'hAAAA_0000; mem[22] = 32'hBBBB_0000; // memory move R4
    mem[23] = 32'h2000_0008; mem[24] = 32'h0000_2000; mem[25] = 32'hE1E1_0001; // indirect +1 R5
    mem[26] = 32'hF000_0004; mem[27] = 32'h0000_3000; mem[28] = 32'h5A5A_5A5A;
    mem[29] = 32'hE2E2_0002; mem[30] = 32'hE3E3_0003;                          // memory move indirect +2 R5
    mem[31] = 32'h8000_0000; mem[32] = 32'h0000_4000;                          // plain transfer-control
    mem[33] = 32'h8800_0000; mem[34] = 32'h0000_5000;                          // interrupt R8

    wait (cyc == 2); #1;
    check(!mem_rd_valid && !ins_valid && !seq_irq && !seq_err, "R1 reset state",
          {28'h0, mem_rd_valid, ins_valid, seq_irq, seq_err}, 32'h0);
    wait (cyc == 6);

    // run 1: R2 start, R7 chaining, R11 busy write ignored, R8 interrupt halt
    pend_data = 32'h40; pend_wr = 1'b1;
    wait (issued == 2);
    pend_data = 32'h80; pend_wr = 1'b1;
    wait (m_ph == 5); #1;
    check(issued == 6, "R8 issued before interrupt", 32'(issued), 32'd6);
    check(seq_irq && !seq_err, "R8 irq only", {30'h0, seq_irq, seq_err}, 32'h2);
    check(m_ptr == 32'h8C, "R11 pointer after run", m_ptr, 32'h8C);

    // run 2: R10 execution error on third instruction
    base = issued; exerr_at = base + 3;
    pend_data = 32'h40; pend_wr = 1'b1;
    wait (m_ph != 5); wait (m_ph == 5); #1;
    check(seq_irq && seq_err, "R10 exec error halt", {30'h0, seq_irq, seq_err}, 32'h3);
    check(issued == base + 3, "R10 issued count", 32'(issued), 32'(base + 3));
    repeat (5) @(negedge clk); #1;
    check(seq_irq && seq_err, "R12 sticky flags", {30'h0, seq_irq, seq_err}, 32'h3);

    // run 3: R9 memory error mid memory-move
    exerr_at = -1; err_idx = 21; base = issued;
    pend_data = 32'h50; pend_wr = 1'b1;
    wait (m_ph != 5); wait (m_ph == 5); #1;
    check(seq_irq && seq_err, "R9 mem error halt", {30'h0, seq_irq, seq_err}, 32'h3);
    check(issued == base, "R9 nothing handed off", 32'(issued), 32'(base));

    // run 4: R2 restart clears flags, indirect and memory move shapes
    err_idx = 63; base = issued;
    pend_data = 32'h5C; pend_wr = 1'b1;
    wait (m_ph != 5); #1;
    check(!seq_err, "R2 flags cleared", 32'(seq_err), 32'h0);
    wait (m_ph == 5); #1;
    check(issued == base + 3, "R5 issued count", 32'(issued), 32'(base + 3));
    check(seq_irq && !seq_err, "R8 second interrupt", {30'h0, seq_irq, seq_err}, 32'h2);
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule